// File: doc/BRIEF.md
# Dual Down-Counter Timer Block

The block holds two down-counter timer channels behind one 4 KB register window. A byte address selects a channel by its 32-byte slot, and the word inside that slot selects the channel register. Each channel counts on its own tick-enable input, so the two channels can run at different rates taken from a shared clock. The masked interrupts of the two channels merge into one interrupt output.

The top 32 bytes of the window hold eight read-only identification words, one byte in each. Every other location reads as zero. This includes the two integration-test words, which do nothing. Writes anywhere outside the two channel slots are dropped. Read data is registered: it appears on the cycle after the read strobe and is held until the next read.

Each channel has a load value, a current count, a control byte, an interrupt-clear word and two status words. In the control byte, bit 7 enables counting and bit 6 selects periodic reload. Bit 0 selects one-shot, which stops at zero. Bit 1 selects 32-bit counting; when it is clear, the count is 16-bit. Bits 3:2 set the tick prescale: 00 divides by 1, 01 by 16, 10 by 256. Bit 5 unmasks the interrupt.

Top module: `dual_tick_timer`

## Requirements
- R1: Byte offsets 0x000–0x01F address channel 0 and 0x020–0x03F address channel 1. Within a slot, offset bits [4:2] give the word index; offset bits [1:0] are ignored.
- R2: The channel words are as follows:
  - Word 0: load value, read/write. A write also sets the count.
  - Word 1: current count, read-only. Writes to it are ignored.
  - Word 2: control byte, bits [7:0]. It reads as 0x20 after reset.
  - Word 3: write-only clear.
  - Word 4: raw interrupt, bit 0.
  - Word 5: raw interrupt ANDed with control bit 5.
  - Word 6: load value. A write to it leaves the count unchanged.
  - Word 7: reads 0.
- R3: Offsets 0xFE0, 0xFE4, … 0xFFC read 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, in bits [7:0], with bits [31:8] zero.
- R4: Reads of any other offset return zero. This covers 0xF00, 0xF04 and 0x040–0xFDC.
- R5: A write to an offset outside 0x000–0x03F changes no register and no output.
- R6: rdata_o shows the addressed word on the cycle after rd_i is sampled high and keeps its value while rd_i is low.
- R7: irq_o is high while at least one channel has its raw interrupt set with control bit 5 set.
- R8: A channel changes its count only on a cycle where its own tick input is high. With control 0xE0 (enable, periodic, unmask, divide by 1) and count N ≥ 1, the raw interrupt sets on the N-th tick and the count reloads to N. With control bit 1 clear, a load write sets the count to the low 16 bits of the value.
- R9: A write to word 3 clears that channel's raw interrupt. A terminal tick in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick0_i | input | 1 | Count enable for channel 0 |
| tick1_i | input | 1 | Count enable for channel 1 |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Merged interrupt |

## Verification
The assertions check several rules on every cycle:
- Undefined and identification reads return zero in the forbidden bits.
- Read data holds between reads.
- Writes outside a slot, or to another slot, leave a channel's load and control unchanged.
- A count moves only on its tick or on a load write.
- A clear with no terminal tick drops the raw interrupt.
- The merged interrupt rises only after a tick or a write.

Only the bench's scenarios can show the following:
- The exact decoded value of every word across the whole window, before and after stray writes.
- The identification byte order.
- The N-tick interrupt timing.
- The OR of the two channels while they are cleared one at a time.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int N_CH     = 2;
  localparam int SLOT_LSB = 5;
  localparam int REGION_W = ADDR_W - SLOT_LSB;
  localparam logic [REGION_W-1:0] ID_REGION = '1;
  localparam logic [7:0] CTRL_RESET = 8'h20;

  typedef enum logic [2:0] {
    W_LOAD = 3'd0, W_COUNT = 3'd1, W_CTRL = 3'd2, W_CLR = 3'd3,
    W_RAW  = 3'd4, W_MSK   = 3'd5, W_BGLD = 3'd6, W_NONE = 3'd7
  } word_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtim_prescale.sv
module dtim_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  always_comb begin
    case (sel_i)
      2'b01:   wrap = (pre_q[3:0] == 4'hF);
      2'b10:   wrap = (pre_q == {PRE_W{1'b1}});
      default: wrap = 1'b1;
    endcase
  end

  assign tick_o = tick_i & en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (tick_i && en_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/dtim_chan.sv
module dtim_chan
  import dtim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [2:0]        widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] MASK16 = DATA_W'(32'h0000_FFFF);

  logic [DATA_W-1:0] load_q, cnt_q, cnt_mask, reload_val;
  logic [7:0]        ctrl_q;
  logic              raw_q, tick_eff, hit, ld_wr, bg_wr, ctrl_wr, clr_wr;

  assign ld_wr   = sel_i & wr_i & (widx_i == W_LOAD);
  assign bg_wr   = sel_i & wr_i & (widx_i == W_BGLD);
  assign ctrl_wr = sel_i & wr_i & (widx_i == W_CTRL);
  assign clr_wr  = sel_i & wr_i & (widx_i == W_CLR);

  assign cnt_mask = ctrl_q[1] ? '1 : MASK16;
  // free-running reloads to the top of the range
  assign reload_val = (ctrl_q[6] | ctrl_q[0]) ? (load_q & cnt_mask) : cnt_mask;

  dtim_prescale #(.PRE_W(8)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .en_i  (ctrl_q[7]),
    .clr_i (ctrl_wr),
    .sel_i (ctrl_q[3:2]),
    .tick_o(tick_eff)
  );

  assign hit = tick_eff & (cnt_q <= DATA_W'(1)) & ~(ctrl_q[0] & (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= CTRL_RESET;
      raw_q  <= 1'b0;
    end else begin
      if (ld_wr || bg_wr) load_q <= wdata_i;
      if (ctrl_wr)        ctrl_q <= wdata_i[7:0];
      if (ld_wr)                  cnt_q <= wdata_i & cnt_mask;
      else if (hit)               cnt_q <= ctrl_q[0] ? '0 : reload_val;
      else if (tick_eff && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (hit)         raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    case (widx_i)
      W_LOAD, W_BGLD: rdata_o = load_q;
      W_COUNT:        rdata_o = cnt_q;
      W_CTRL:         rdata_o = {{(DATA_W-8){1'b0}}, ctrl_q};
      W_RAW:          rdata_o = {{(DATA_W-1){1'b0}}, raw_q};
      W_MSK:          rdata_o = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q[5]};
      default:        rdata_o = '0;
    endcase
  end

  assign irq_o = raw_q & ctrl_q[5];

  assert_clear_drops_raw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !hit) |=> !raw_q);
  assert_count_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_wr) |=> $stable(cnt_q));
  assert_foreign_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> ($stable(ctrl_q) && $stable(load_q)));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick0_i,
  input  logic              tick1_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [REGION_W-1:0] region;
  logic [2:0]          widx;
  logic [N_CH-1:0]     ch_sel, ch_irq, ch_tick;
  logic [DATA_W-1:0]   ch_rdata [N_CH];
  logic [DATA_W-1:0]   rd_mux;
  logic                id_hit, undef_hit;
  logic                unused_lsb;

  assign region     = addr_i[ADDR_W-1:SLOT_LSB];
  assign widx       = addr_i[4:2];
  assign unused_lsb = ^addr_i[1:0];
  assign ch_tick    = {tick1_i, tick0_i};
  assign id_hit     = (region == ID_REGION);
  assign undef_hit  = ~id_hit & ~(|ch_sel);

  for (genvar i = 0; i < N_CH; i++) begin : gen_ch
    assign ch_sel[i] = (region == REGION_W'(i));
    dtim_chan u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (ch_tick[i]),
      .sel_i  (ch_sel[i]),
      .wr_i   (wr_i),
      .widx_i (widx),
      .wdata_i(wdata_i),
      .rdata_o(ch_rdata[i]),
      .irq_o  (ch_irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) rd_mux = {{(DATA_W-8){1'b0}}, id_byte(widx)};
    for (int i = 0; i < N_CH; i++)
      if (ch_sel[i]) rd_mux = ch_rdata[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign irq_o = |ch_irq;

  assert_undef_read_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && undef_hit) |=> (rdata_o == '0));
  assert_id_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && id_hit) |=> (rdata_o[DATA_W-1:8] == '0));
  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick0_i || tick1_i || wr_i));
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick0 = 1'b0, tick1 = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  logic [31:0] ld [2], val [2];
  logic [7:0]  ctl [2];
  logic        raw [2];

  always #4 clk = ~clk;

  dual_tick_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick0_i(tick0), .tick1_i(tick1),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] idv(int k);
    case (k)
      0: idv = 8'h04; 1: idv = 8'h18; 2: idv = 8'h14; 3: idv = 8'h00;
      4: idv = 8'h0D; 5: idv = 8'hF0; 6: idv = 8'h05; default: idv = 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    int r = a >> 5;
    int w = (a >> 2) & 7;
    exp_rd = '0;
    if (r < 2) begin
      case (w)
        0, 6: exp_rd = ld[r];
        1:    exp_rd = val[r];
        2:    exp_rd = {24'h0, ctl[r]};
        4:    exp_rd = {31'h0, raw[r]};
        5:    exp_rd = {31'h0, raw[r] & ctl[r][5]};
        default: exp_rd = '0;
      endcase
    end else if (r == 127) exp_rd = {24'h0, idv(w)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrw(int a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rdw(int a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = 12'(a);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(int ch, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (ch == 0) tick0 = 1'b1; else tick1 = 1'b1;
      @(negedge clk); tick0 = 1'b0; tick1 = 1'b0;
    end
  endtask

  task automatic sweep(string tag);
    logic [31:0] d;
    for (int a = 0; a < 4096; a += 4) begin
      rdw(a + (a & 3), d);
      chk(tag, d, exp_rd(a));
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 2; i++) begin
      ld[i] = '0; val[i] = '0; ctl[i] = 8'h20; raw[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R7 reset irq", {31'h0, irq}, 32'h0);
    chk("R6 reset rdata", rdata, 32'h0);
    // R1 R2 R3 R4 full window after reset
    sweep("R1/R3/R4 reset sweep");

    // R1 R8: 16-bit count mask on load
    wrw(12'h000, 32'hA5A5_1234); ld[0] = 32'hA5A5_1234; val[0] = 32'h1234;
    wrw(12'h020, 32'h5A5A_5678); ld[1] = 32'h5A5A_5678; val[1] = 32'h5678;
    rdw(12'h004, d); chk("R8 16-bit load ch0", d, 32'h1234);
    rdw(12'h03A, d); chk("R1 ch1 bgload alias", d, 32'h5A5A_5678);
    // R6 hold
    @(negedge clk); chk("R6 hold", rdata, 32'h5A5A_5678);
    // R2 count word read-only
    wrw(12'h004, 32'hFFFF_FFFF);
    rdw(12'h004, d); chk("R2 count read-only", d, 32'h1234);
    // R2 bgload keeps count
    wrw(12'h018, 32'h0000_0007); ld[0] = 32'h7;
    rdw(12'h004, d); chk("R2 bgload keeps count", d, 32'h1234);
    rdw(12'h000, d); chk("R2 bgload sets load", d, 32'h7);
    // R5 stray writes
    wrw(12'h040, 32'hFFFF_FFFF);
    wrw(12'hF00, 32'hFFFF_FFFF);
    wrw(12'hF04, 32'hFFFF_FFFF);
    wrw(12'hFE0, 32'hFFFF_FFFF);
    wrw(12'h808, 32'h0000_00FF);
    chk("R5 irq after stray writes", {31'h0, irq}, 32'h0);
    sweep("R5 sweep after stray writes");

    // R8 periodic count, own tick only
    wrw(12'h000, 32'd3); ld[0] = 32'd3;
    wrw(12'h008, 32'h0000_00E0);
    pulse(0, 1);
    rdw(12'h004, d); chk("R8 one tick", d, 32'd2);
    pulse(1, 4);
    rdw(12'h004, d); chk("R8 ch0 ignores tick1", d, 32'd2);
    rdw(12'h024, d); chk("R8 ch1 stopped", d, 32'h5678);
    pulse(0, 1);
    chk("R8 no irq before N", {31'h0, irq}, 32'h0);
    pulse(0, 1);
    chk("R8 irq at N", {31'h0, irq}, 32'h1);
    rdw(12'h004, d); chk("R8 reload", d, 32'd3);
    rdw(12'h010, d); chk("R2 raw word", d, 32'h1);
    rdw(12'h034, d); chk("R8 ch1 raw untouched", d, 32'h0);

    // R7 OR merge
    wrw(12'h020, 32'd2);
    wrw(12'h028, 32'h0000_00E0);
    pulse(1, 2);
    rdw(12'h030, d); chk("R8 ch1 raw", d, 32'h1);
    wrw(12'h00C, 32'h0);
    rdw(12'h010, d); chk("R9 clear ch0", d, 32'h0);
    chk("R7 ch1 alone", {31'h0, irq}, 32'h1);
    wrw(12'h02C, 32'h0);
    chk("R7 both clear", {31'h0, irq}, 32'h0);

    // R7 mask
    wrw(12'h008, 32'h0000_00C0);
    pulse(0, 3);
    rdw(12'h010, d); chk("R2 raw masked", d, 32'h1);
    rdw(12'h014, d); chk("R2 masked word", d, 32'h0);
    chk("R7 masked irq", {31'h0, irq}, 32'h0);
    wrw(12'h008, 32'h0000_00E0);
    chk("R7 unmask", {31'h0, irq}, 32'h1);
    rdw(12'h014, d); chk("R2 masked word set", d, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule